// File: doc/BRIEF.md
# Pipeline Stage with Registered Stall and Overflow Slot

This block is one stage of a valid/data pipeline that feeds a shared, arbitrated resource. Stages are chained output to input, and each stage's `stall_out` drives the `stall_in` of the stage in front of it. The stall a stage sends upstream comes from a flip-flop. Backpressure therefore moves back one stage per clock, and no single wire has to reach every stage in one cycle.

Because the stall reaches the upstream neighbour one cycle late, that neighbour can still hand over one more item after the stage has stopped draining. The stage keeps that late item in an overflow slot next to its regular output register. When the stall lifts, the regular slot leaves first, then the overflowed item, and only after that is new upstream data taken. A synchronous flush empties both slots and takes priority over everything else.

An item moves across the input boundary at a clock edge when `in_valid` is high and `stall_out` is low. It moves across the output boundary when `out_valid` is high and `stall_in` is low.

Top module: `stall_skid_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` and `stall_out` are 0.
- R2: When the stage is empty and not stalled, an accepted input item appears on `out_data` with `out_valid` high in the next cycle. Back-to-back inputs give one output per cycle.
- R3: While `out_valid` and `stall_in` are both high and `flush` is low, `out_valid` stays high and `out_data` is unchanged in the next cycle.
- R4: If `stall_in` is high while the regular slot holds an item, `stall_out` is high in the next cycle, whether or not an item arrives.
- R5: An item accepted while the regular slot is stalled goes into the overflow slot. While `stall_out` is high, `in_valid` and `in_data` have no effect, and stay without effect while `stall_in` remains high.
- R6: After a stall with items A (regular) and B (overflow), the output presents A, then B, then the next upstream item C, each in consecutive cycles once `stall_in` is low.
- R7: If `stall_in` is low in a cycle and `flush` is low, `stall_out` is low in the next cycle.
- R8: A cycle with `flush` high leaves `out_valid` and `stall_out` low in the next cycle, regardless of `in_valid` or `stall_in`. Neither slot's former content, nor the input offered in the flush cycle, ever appears at the output.
- R9: Under any pattern of `stall_in`, every accepted item leaves exactly once, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Synchronous clear of both slots |
| in_valid | input | 1 | Upstream item present |
| in_data | input | W | Upstream item payload |
| stall_in | input | 1 | Downstream cannot take the output this cycle |
| out_valid | output | 1 | Output item present |
| out_data | output | W | Output item payload |
| stall_out | output | 1 | Registered stall to the upstream stage |

## Verification
The assertions assume an upstream that follows the handshake: an item offered while `stall_out` is high is treated as not taken, and the upstream offers it again later. They also assume `flush` is sampled on the same clock as the data. The bench's upstream model moves to its next item only in a cycle where it offered one while `stall_out` was low. Its `stall_in` pattern is chosen per cycle before the handover is decided, so the stage always sees a legal neighbour.

// File: rtl/stall_skid_stage.sv
module stall_skid_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         stall_in,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         stall_out
);

  logic         reg_v, ovf_v;
  logic [W-1:0] reg_d, ovf_d;
  logic         take, accept;
  logic         reg_v_nx, ovf_v_nx;
  logic [W-1:0] reg_d_nx, ovf_d_nx;

  assign take   = reg_v & ~stall_in;
  assign accept = in_valid & ~stall_out;

  always_comb begin
    reg_v_nx = reg_v;
    reg_d_nx = reg_d;
    ovf_v_nx = ovf_v;
    ovf_d_nx = ovf_d;
    if (ovf_v) begin
      if (take) begin
        reg_d_nx = ovf_d;
        ovf_v_nx = 1'b0;
      end
    end else if (!reg_v || take) begin
      reg_v_nx = accept;
      if (accept) reg_d_nx = in_data;
    end else if (accept) begin
      ovf_v_nx = 1'b1;
      ovf_d_nx = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      reg_v     <= 1'b0;
      ovf_v     <= 1'b0;
      stall_out <= 1'b0;
    end else begin
      reg_v     <= reg_v_nx;
      ovf_v     <= ovf_v_nx;
      stall_out <= ovf_v_nx | (reg_v_nx & stall_in);
    end
  end

  always_ff @(posedge clk) begin
    reg_d <= reg_d_nx;
    ovf_d <= ovf_d_nx;
  end

  assign out_valid = reg_v;
  assign out_data  = reg_d;

endmodule

// File: rtl/stall_skid_stage_chk.sv
module stall_skid_stage_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         stall_in,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         stall_out
);

  assert_hold_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stall_in && !flush) |=> (out_valid && $stable(out_data)));

  assert_stall_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stall_in && !flush) |=> stall_out);

  assert_stall_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_out && stall_in && !flush) |=> stall_out);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_in && !flush) |=> !stall_out);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !stall_out));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall_out && !out_valid && !flush) |=>
      (out_valid && out_data == $past(in_data)));

endmodule

bind stall_skid_stage stall_skid_stage_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .in_data(in_data), .stall_in(stall_in), .out_valid(out_valid),
  .out_data(out_data), .stall_out(stall_out)
);

// File: tb/stall_skid_stage_tb_top.sv
module stall_skid_stage_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         stall_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         stall_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stall_skid_stage #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_data(in_data), .stall_in(stall_in), .out_valid(out_valid),
    .out_data(out_data), .stall_out(stall_out)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; in_valid = 0; stall_in = 0;
    tick(); tick();
  endtask

  task automatic test_reset();
    rst_n = 0;
    tick(); tick();
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 stall_out in reset", stall_out, 0);
    rst_n = 1;
    tick();
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 stall_out after reset", stall_out, 0);
  endtask

  task automatic test_stream();
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_data = W'(8'h10 + i);
      tick();
      check("R2 stream valid", out_valid, 1);
      check("R2 stream data", out_data, 8'h10 + i);
    end
    in_valid = 0;
    tick();
    check("R2 drained", out_valid, 0);
  endtask

  task automatic test_stall_order();
    in_valid = 1; in_data = 8'hA1; stall_in = 0;
    tick();
    check("R2 A loaded", out_data, 8'hA1);
    stall_in = 1; in_data = 8'hB2;
    tick();
    check("R3 A held", out_data, 8'hA1);
    check("R5 stall_out after overflow", stall_out, 1);
    in_data = 8'hC3;
    tick();
    check("R3 A still held", out_data, 8'hA1);
    check("R5 stall_out kept", stall_out, 1);
    stall_in = 0;
    tick();
    check("R6 B second", out_data, 8'hB2);
    check("R6 B valid", out_valid, 1);
    check("R7 stall_out released", stall_out, 0);
    tick();
    check("R6 C third", out_data, 8'hC3);
    in_valid = 0;
    tick();
    check("R6 empty after C", out_valid, 0);
  endtask

  task automatic test_stall_no_arrival();
    in_valid = 1; in_data = 8'h44;
    tick();
    in_valid = 0; stall_in = 1;
    tick();
    check("R4 stall forwarded without arrival", stall_out, 1);
    check("R3 held", out_data, 8'h44);
    stall_in = 0;
    tick();
    check("R7 stall dropped", stall_out, 0);
    check("R4 item left", out_valid, 0);
  endtask

  task automatic test_flush();
    in_valid = 1; in_data = 8'h51;
    tick();
    stall_in = 1; in_data = 8'h52;
    tick();
    flush = 1; in_data = 8'h53;
    tick();
    check("R8 out_valid cleared", out_valid, 0);
    check("R8 stall_out cleared", stall_out, 0);
    flush = 0; in_valid = 0; stall_in = 0;
    tick();
    check("R8 overflow gone", out_valid, 0);
    tick();
    check("R8 still empty", out_valid, 0);
  endtask

  task automatic test_order_random();
    int sent = 0;
    int got = 0;
    int bad = 0;
    for (int c = 0; c < 200 && got < 40; c++) begin
      stall_in = ((c % 7) == 2) || ((c % 7) == 3) || ((c % 11) == 5);
      in_valid = (sent < 40) && ((c % 13) != 4);
      in_data = W'(sent);
      if (out_valid && !stall_in) begin
        if (out_data != W'(got)) bad++;
        got++;
      end
      if (in_valid && !stall_out) sent++;
      tick();
    end
    in_valid = 0; stall_in = 0;
    check("R9 items received", got, 40);
    check("R9 order errors", bad, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_stream();
    idle();
    test_stall_order();
    idle();
    test_stall_no_arrival();
    idle();
    test_flush();
    idle();
    test_order_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule